// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. Four pins drive it: a test clock, a mode-select line, a serial data input and an active-low power-on reset. The mode-select value sampled on each rising test-clock edge moves a sixteen-state machine through the standard boundary-scan sequence. That sequence has a reset state, an idle state, and two scan branches, one for the instruction register and one for a data register. Each branch has capture, shift, pause, exit and update states. There is no separate test-reset pin. The power-on reset, or five clocks with mode-select held high, returns the port to its reset state. In the reset state the identification instruction is selected at once, and the chip's normal logic runs undisturbed.

A 4-bit instruction register picks the data register that sits between the serial input and the serial output. Code 0010 selects a built-in 32-bit identification register. Codes EXT_OP_BASE+i select external register i. Code 1111 and every other code select a 1-bit bypass stage. Because of this, a serial input left floating high scans in the bypass instruction. For external registers the block provides only the capture, shift and update strobes and one select line each. It also takes each external register's serial output back in. The serial output and its enable change on the falling test-clock edge and are driven only while a register is shifting.

Top module: `scan_port_ctrl`

## Requirements
- R1: While por_n is low, the port is held in its reset state at once, without waiting for a clock edge: tdo=0, tdo_oe=0, every strobe low and every ext_sel bit low.
- R2: State changes follow the standard boundary-scan graph, using tms sampled on the rising edge of tck. dr_capture, dr_shift and dr_update are high exactly while the machine is in Capture-DR, Shift-DR and Update-DR.
- R3: Starting from any state, five rising edges with tms=1 reach the reset state.
- R4: Capture-IR loads the instruction shift stage with 0001. Shift-IR moves it one place toward tdo per edge, taking tdi into bit 3 and sending bit 0 first.
- R5: The active instruction changes only on the edge that leaves Update-IR, or in the reset state. It stays fixed through shifting and pausing.
- R6: In the reset state the identification instruction (code 0010) is selected, without any scan being needed.
- R7: Under the identification instruction, Capture-DR loads IDCODE_VALUE, whose bit 0 is 1. Shift-DR then sends it out bit 0 first.
- R8: Code 1111, and any code that is neither 0010 nor an external code, selects bypass. Bypass captures 0 and delays tdi to tdo by one stage.
- R9: ext_sel[i] is high exactly while the active instruction equals EXT_OP_BASE+i (defaults 1000 and 1001). While that instruction is active, tdo in Shift-DR carries ext_tdo[i].
- R10: tdo and tdo_oe change only on the falling edge of tck. tdo_oe is high only after a falling edge taken in Shift-IR or Shift-DR, and tdo is 0 whenever tdo_oe is low.
- R11: Pause-IR and Pause-DR hold the shift stage unchanged. Shifting resumes from the same bit after Exit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| ext_tdo | input | N_EXT | Serial outputs of the external data registers |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| dr_capture | output | 1 | High in Capture-DR |
| dr_shift | output | 1 | High in Shift-DR |
| dr_update | output | 1 | High in Update-DR |
| ext_sel | output | N_EXT | Per-external-register select from instruction decode |

## Verification
A wrong state encoding or a wrong transition shows up within one clock as a misplaced strobe, because the three data-register strobes decode the state directly. A fault that stays inside the instruction path only becomes visible at the next shift or select. A corrupted instruction changes ext_sel immediately, and changes the bit order or length seen on tdo at the next Shift-DR. The reference model follows every clock, so a fault in the shift stage shows up half a cycle after the bit reaches position 0, on the next falling edge.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

    localparam int IR_W = 4;

    // instruction codes with fixed meaning
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SH_DR  = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SH_IR  = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_e;

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    assign state = state_q;

    assert_reset_hold_R3: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_RESET && tms) |=> (state_q == ST_RESET));

    assert_shift_stay_R2: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_SH_DR && !tms) |=> (state_q == ST_SH_DR));

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
    import scan_port_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            ir_tdo,
    output logic [IR_W-1:0] instr
);

    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] ir;
    } ir_regs_t;

    ir_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (state)
            ST_CAP_IR: regs_d.sr = IR_CAPTURE;
            ST_SH_IR:  regs_d.sr = {tdi, regs_q.sr[IR_W-1:1]};
            ST_UPD_IR: regs_d.ir = regs_q.sr;
            ST_RESET:  regs_d.ir = OP_IDCODE;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) regs_q <= '{sr: IR_CAPTURE, ir: OP_IDCODE};
        else        regs_q <= regs_d;
    end

    assign ir_tdo = regs_q.sr[0];
    // reset state selects the identification register without a clock edge
    assign instr  = (state == ST_RESET) ? OP_IDCODE : regs_q.ir;

    assert_ir_stable_R5: assert property (@(posedge tck) disable iff (!por_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(regs_q.ir));

    assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_IR) |=> (ir_tdo == 1'b1));

endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
    import scan_port_pkg::*;
#(
    parameter int          ID_W        = 32,
    parameter logic [31:0] IDCODE_VALUE = 32'h2B7D_4C59,
    parameter int          N_EXT       = 2,
    parameter int          EXT_OP_BASE = 8
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tdi,
    input  tap_state_e       state,
    input  logic [IR_W-1:0]  instr,
    input  logic [N_EXT-1:0] ext_tdo,
    output logic             dr_tdo,
    output logic [N_EXT-1:0] ext_sel
);

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            byp;
    } dr_regs_t;

    dr_regs_t regs_d, regs_q;
    logic     id_sel, byp_sel, ext_bit;

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        assign ext_sel[i] = (instr == IR_W'(EXT_OP_BASE + i));
    end

    assign id_sel  = (instr == OP_IDCODE);
    assign byp_sel = !id_sel && !(|ext_sel);

    always_comb begin
        ext_bit = 1'b0;
        for (int i = 0; i < N_EXT; i++) begin
            if (ext_sel[i]) ext_bit = ext_tdo[i];
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (state == ST_CAP_DR) begin
            if (id_sel)  regs_d.id  = IDCODE_VALUE[ID_W-1:0];
            if (byp_sel) regs_d.byp = 1'b0;
        end else if (state == ST_SH_DR) begin
            if (id_sel)  regs_d.id  = {tdi, regs_q.id[ID_W-1:1]};
            if (byp_sel) regs_d.byp = tdi;
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) regs_q <= '{id: IDCODE_VALUE[ID_W-1:0], byp: 1'b0};
        else        regs_q <= regs_d;
    end

    assign dr_tdo = id_sel ? regs_q.id[0] : (byp_sel ? regs_q.byp : ext_bit);

    assert_bypass_zero_R8: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && byp_sel) |=> (regs_q.byp == 1'b0));

    assert_ext_onehot_R9: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0(ext_sel));

    assert_id_lsb_R7: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && id_sel) |=> (regs_q.id[0] == 1'b1));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_port_pkg::*;
#(
    parameter logic [31:0] IDCODE_VALUE = 32'h2B7D_4C59,
    parameter int          N_EXT       = 2,
    parameter int          EXT_OP_BASE = 8
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [N_EXT-1:0] ext_tdo,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             dr_capture,
    output logic             dr_shift,
    output logic             dr_update,
    output logic [N_EXT-1:0] ext_sel
);

    localparam int ID_W = 32;

    typedef struct packed {
        logic dout;
        logic oe;
    } out_regs_t;

    tap_state_e      state;
    logic            ir_tdo, dr_tdo;
    logic [IR_W-1:0] instr;
    out_regs_t       out_d, out_q;

    scan_port_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    scan_port_ir u_ir (
        .tck    (tck),
        .por_n  (por_n),
        .tdi    (tdi),
        .state  (state),
        .ir_tdo (ir_tdo),
        .instr  (instr)
    );

    scan_port_dr #(
        .ID_W         (ID_W),
        .IDCODE_VALUE (IDCODE_VALUE),
        .N_EXT        (N_EXT),
        .EXT_OP_BASE  (EXT_OP_BASE)
    ) u_dr (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .state   (state),
        .instr   (instr),
        .ext_tdo (ext_tdo),
        .dr_tdo  (dr_tdo),
        .ext_sel (ext_sel)
    );

    assign dr_capture = (state == ST_CAP_DR);
    assign dr_shift   = (state == ST_SH_DR);
    assign dr_update  = (state == ST_UPD_DR);

    always_comb begin
        out_d = '0;
        if (state == ST_SH_IR) begin
            out_d.dout = ir_tdo;
            out_d.oe   = 1'b1;
        end else if (state == ST_SH_DR) begin
            out_d.dout = dr_tdo;
            out_d.oe   = 1'b1;
        end
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo    = out_q.dout;
    assign tdo_oe = out_q.oe;

    assert_oe_in_shift_R10: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    assert_tdo_quiet_R10: assert property (@(posedge tck) disable iff (!por_n)
        !tdo_oe |-> !tdo);

endmodule

// File: tb/scan_port_ctrl_tb.sv
module scan_port_ctrl_tb;

    localparam logic [31:0] IDV  = 32'h2B7D_4C59;
    localparam bit   [3:0]  IDC  = 4'b0010;
    localparam int          NEXT = 2;

    // reference state numbering, independent of the design
    localparam int TLR = 0, IDL = 1, SDR = 2, CDR = 3, HDR = 4, X1D = 5, PDR = 6, X2D = 7,
                   UDR = 8, SIR = 9, CIR = 10, HIR = 11, X1I = 12, PIR = 13, X2I = 14, UIR = 15;

    logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b1;
    logic [NEXT-1:0] ext_tdo = '0;
    logic tdo, tdo_oe, dr_capture, dr_shift, dr_update;
    logic [NEXT-1:0] ext_sel;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int       m_st = TLR;
    bit [3:0] m_ir = IDC, m_irsr = 4'b0001;
    bit [31:0] m_id = IDV;
    bit       m_byp = 0, e_tdo = 0, e_oe = 0;
    bit [15:0] lf = 16'hACE1;

    always #5 tck = ~tck;

    scan_port_ctrl #(.IDCODE_VALUE(IDV), .N_EXT(NEXT), .EXT_OP_BASE(8)) u_dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .ext_tdo(ext_tdo),
        .tdo(tdo), .tdo_oe(tdo_oe), .dr_capture(dr_capture), .dr_shift(dr_shift),
        .dr_update(dr_update), .ext_sel(ext_sel)
    );

    function automatic bit rnd();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    function automatic int nxt(int s, bit m);
        case (s)
            TLR: return m ? TLR : IDL;
            IDL: return m ? SDR : IDL;
            SDR: return m ? SIR : CDR;
            CDR, HDR: return m ? X1D : HDR;
            X1D: return m ? UDR : PDR;
            PDR: return m ? X2D : PDR;
            X2D: return m ? UDR : HDR;
            SIR: return m ? TLR : CIR;
            CIR, HIR: return m ? X1I : HIR;
            X1I: return m ? UIR : PIR;
            PIR: return m ? X2I : PIR;
            X2I: return m ? UIR : HIR;
            default: return m ? SDR : IDL; // both update states
        endcase
    endfunction

    function automatic bit [3:0] cur_op();
        return (m_st == TLR) ? IDC : m_ir;
    endfunction

    function automatic int ext_idx();
        bit [3:0] op = cur_op();
        if (op == 4'b1000) return 0;
        if (op == 4'b1001) return 1;
        return -1;
    endfunction

    task automatic model_pos(bit m, bit d);
        int x = ext_idx();
        case (m_st)
            CIR: m_irsr = 4'b0001;
            HIR: m_irsr = {d, m_irsr[3:1]};
            UIR: m_ir = m_irsr;
            TLR: m_ir = IDC;
            CDR: if (cur_op() == IDC) m_id = IDV; else if (x < 0) m_byp = 0;
            HDR: if (cur_op() == IDC) m_id = {d, m_id[31:1]}; else if (x < 0) m_byp = d;
            default: ;
        endcase
        m_st = nxt(m_st, m);
    endtask

    task automatic model_neg();
        int x = ext_idx();
        e_oe = (m_st == HIR) || (m_st == HDR);
        if (m_st == HIR) e_tdo = m_irsr[0];
        else if (m_st == HDR) e_tdo = (cur_op() == IDC) ? m_id[0] : (x >= 0 ? ext_tdo[x] : m_byp);
        else e_tdo = 0;
    endtask

    task automatic chk(string what, string tag, logic act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        int x = ext_idx();
        chk("tdo", tag, tdo, e_tdo);
        chk("tdo_oe", tag, tdo_oe, e_oe);
        chk("dr_capture", tag, dr_capture, m_st == CDR);
        chk("dr_shift", tag, dr_shift, m_st == HDR);
        chk("dr_update", tag, dr_update, m_st == UDR);
        for (int i = 0; i < NEXT; i++) chk("ext_sel", tag, ext_sel[i], x == i);
    endtask

    task automatic step(bit m, bit d, string tag);
        tms = m; tdi = d;
        ext_tdo = {rnd(), rnd()};
        @(posedge tck); model_pos(m, d);
        @(negedge tck); model_neg();
        #1; compare(tag);
    endtask

    task automatic to_idle(string tag);
        for (int i = 0; i < 5; i++) step(1, 1, tag);
        step(0, 0, tag);
    endtask

    task automatic ir_scan(bit [3:0] v, string tag);
        step(1, 0, tag); step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
        for (int i = 0; i < 4; i++) step(i == 3, v[i], tag);
        step(1, 0, tag); step(0, 0, tag);
    endtask

    task automatic dr_scan(int n, int pause_at, string tag);
        step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
        for (int i = 0; i < n; i++) begin
            if (i == pause_at) begin
                step(1, rnd(), tag); step(0, 0, tag); step(0, 0, tag); step(0, 0, tag);
                step(1, 0, tag); step(0, 0, tag);
            end else begin
                step(i == n - 1, rnd(), tag);
            end
        end
        step(1, 0, tag); step(0, 0, tag);
    endtask

    task automatic async_reset(string tag);
        por_n = 0;
        m_st = TLR; m_ir = IDC; m_irsr = 4'b0001; m_id = IDV; m_byp = 0; e_tdo = 0; e_oe = 0;
        #1; compare(tag);
        por_n = 1;
    endtask

    initial begin
        #2; compare("R1");
        #10; por_n = 1;
        step(1, 1, "R1");
        step(0, 0, "R6");
        dr_scan(40, -1, "R7");          // identification register read after reset
        ir_scan(4'b1111, "R4");         // bypass code
        dr_scan(12, -1, "R8");
        ir_scan(4'b0101, "R8");         // undefined code falls to bypass
        dr_scan(10, 4, "R8");
        ir_scan(4'b1000, "R9");
        dr_scan(8, -1, "R9");
        ir_scan(4'b1001, "R9");
        dr_scan(8, 3, "R9");
        // IR scan with a pause in the middle
        step(1, 0, "R11"); step(1, 0, "R11"); step(0, 0, "R11"); step(0, 0, "R11");
        step(0, 0, "R11"); step(1, 1, "R11"); step(0, 0, "R11"); step(0, 0, "R11");
        step(1, 0, "R11"); step(0, 1, "R11"); step(1, 0, "R5"); step(1, 0, "R5"); step(0, 0, "R5");
        dr_scan(34, 9, "R11");
        // open input: tdi stuck high loads bypass
        ir_scan(4'b1111, "R8");
        dr_scan(6, -1, "R10");
        ir_scan(4'b1001, "R10");
        async_reset("R1");
        step(0, 0, "R6");
        dr_scan(33, -1, "R6");
        for (int k = 0; k < 40; k++) begin
            for (int j = 0; j < k % 9; j++) step(rnd(), rnd(), "R3");
            for (int j = 0; j < 5; j++) step(1, rnd(), "R3");
            step(0, 0, "R3"); step(1, 0, "R3"); step(0, 0, "R3"); step(0, 1, "R3"); step(0, 0, "R3");
            to_idle("R3");
        end
        for (int k = 0; k < 400; k++) step(rnd(), rnd(), "R2");
        to_idle("R2");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule